// File: doc/BRIEF.md
# Memory Bank Bus Hand-Over Arbiter

This block decides who drives the bus of one SDRAM bank: the local memory controller or an external master. The external master asks for the bus by raising a request line. The block then tells the local controller to hold off new accesses. It waits until all local work has drained, including any refresh cycle still running. It then stops the bank clock-enable and floats the bank's pins. Only after that does it raise the grant. The clock-enable comes back one cycle after the grant, and from then on the external master drives the bank and is responsible for keeping it refreshed.

When the external master lowers its request, the block drops grant and clock-enable in the same cycle. It keeps the pins floating for a programmed turnaround window. It then takes the pins back while clock-enable is still low, and raises clock-enable once its own drivers are settled. The bank therefore changes owner only while its clock-enable is deasserted. Other memory and card pins are not under the control of this block.

The request line comes from outside the local clock domain, so it passes through a synchronizer first. Both clock-enable-off windows last `CKE_OFF_MIN` cycles.

Top module: `bus_handover`

## Requirements
- R1: After reset, `ext_grant`=0, `bank_cke`=1, `bank_drive_en`=1 (local side drives the bank pins) and `local_hold`=0.
- R2: A rising `ext_req` is seen after `SYNC_STAGES` clock edges. With the default of 2 stages, `local_hold` rises on the third rising edge after the input changes.
- R3: While `local_hold` is high in the drain phase, the pins stay driven locally (`bank_drive_en`=1), `bank_cke` stays 1 and `ext_grant` stays 0 for as long as `local_idle`=0 or `refresh_busy`=1.
- R4: Once drained, `bank_cke`=0 and `bank_drive_en`=0 for exactly `CKE_OFF_MIN` cycles, with `ext_grant`=0, before `ext_grant` rises. `ext_grant` rises while `bank_cke` is still 0.
- R5: `bank_cke` returns to 1 exactly one cycle after `ext_grant` rises, while `bank_drive_en` stays 0.
- R6: `local_hold` is 1 in every cycle in which `ext_grant` is 1, so no local access or refresh starts while the external master owns the bank.
- R7: When the synchronized request falls, `ext_grant` and `bank_cke` drop in the same cycle. `bank_drive_en` stays 0 for `CKE_OFF_MIN` cycles after that.
- R8: After the release window, `bank_drive_en` returns to 1 for one cycle with `bank_cke`=0 and `local_hold`=1. In the next cycle `bank_cke`=1 and `local_hold`=0.
- R9: If the request is withdrawn during the drain phase, the block returns to idle: `local_hold` falls and `ext_grant` is never raised.
- R10: `bank_drive_en` changes value only in cycles where `bank_cke` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req | input | 1 | Bus request from the external master (asynchronous) |
| local_idle | input | 1 | High when no local memory operation is pending or in progress |
| refresh_busy | input | 1 | High while the local controller is running a refresh cycle |
| ext_grant | output | 1 | Bus grant to the external master |
| bank_cke | output | 1 | Clock-enable of the shared SDRAM bank |
| bank_drive_en | output | 1 | 1 = local side drives the bank pins, 0 = pins floated |
| local_hold | output | 1 | Blocks new local operations and refresh |

## Verification
The hardest situation to reach is the drain phase held open while the request is already synchronized. The bench gets there by pulling `local_idle` low, and separately by raising `refresh_busy`, before it raises `ext_req`. It then holds the phase open for several cycles and releases it from the bench. A second hard-to-reach case is a request withdrawn during the drain phase. The bench reaches it by keeping the drain blocked while it drops the request, and then checks that no grant was ever issued.

// File: rtl/bus_handover_pkg.sv
// Shared types for the bank bus hand-over arbiter.
// Assumes: state encodings are internal and free to change.
package bus_handover_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DRAIN    = 3'd1,
        ST_CKE_ACQ  = 3'd2,
        ST_GRANTED  = 3'd3,
        ST_CKE_REL  = 3'd4,
        ST_RESUME   = 3'd5
    } ho_state_t;

endpackage

// File: rtl/ho_req_sync.sv
// Multi-flop synchronizer for the external request line.
// Assumes: the request is level-based and held long enough to be sampled.
module ho_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Purpose: shift the request one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain_q[gi] <= 1'b0;
                else if (gi == 0)
                    chain_q[gi] <= async_in;
                else
                    chain_q[gi] <= chain_q[(gi > 0) ? gi-1 : 0];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ho_phase_timer.sv
// Counts the cycles spent in the current phase and flags the last cycle of a
// window of WINDOW cycles.
// Assumes: phase_start is high on the cycle before a new phase begins.
module ho_phase_timer #(
    parameter int WINDOW = 4,
    localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_start,
    output logic window_done
);
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: restart on a phase change, otherwise count up to the window end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (phase_start)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign window_done = (cnt_q == LAST);

    assert_window_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/ho_fsm.sv
// Hand-over sequencer: drain, clock-enable off, grant, release, resume.
// Assumes: req_s is synchronized; window_done is from ho_phase_timer.
module ho_fsm
    import bus_handover_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic local_idle,
    input  logic refresh_busy,
    input  logic window_done,
    output logic phase_start,
    output logic grant,
    output logic cke,
    output logic drive_en,
    output logic hold
);
    ho_state_t state_q, state_d;
    logic      settled_q;

    // Purpose: choose the next phase from the request, drain status and timer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (req_s) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (!req_s)
                    state_d = ST_IDLE;
                else if (local_idle && !refresh_busy)
                    state_d = ST_CKE_ACQ;
            end
            ST_CKE_ACQ: if (window_done) state_d = ST_GRANTED;
            ST_GRANTED: if (!req_s) state_d = ST_CKE_REL;
            ST_CKE_REL: if (window_done) state_d = ST_RESUME;
            ST_RESUME:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign phase_start = (state_d != state_q);

    // Purpose: hold the current phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Purpose: note that the grant has been visible for at least one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            settled_q <= 1'b0;
        else
            settled_q <= (state_q == ST_GRANTED);
    end

    // Purpose: decode the bank controls from the phase.
    always_comb begin
        grant    = 1'b0;
        cke      = 1'b1;
        drive_en = 1'b1;
        hold     = 1'b1;
        case (state_q)
            ST_IDLE:    hold = 1'b0;
            ST_DRAIN:   ;
            ST_CKE_ACQ: begin cke = 1'b0; drive_en = 1'b0; end
            ST_GRANTED: begin grant = 1'b1; cke = settled_q; drive_en = 1'b0; end
            ST_CKE_REL: begin cke = 1'b0; drive_en = 1'b0; end
            ST_RESUME:  cke = 1'b0;
            default:    hold = 1'b0;
        endcase
    end

    assert_owner_swap_cke_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive_en) |-> !cke);
    assert_grant_pins_floated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !drive_en);
    assert_grant_after_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> (!cke && $past(window_done) && $past(!cke)));
    assert_cke_back_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |=> (cke || !grant));
    assert_hold_while_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> hold);
    assert_release_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant) |-> (!cke && !drive_en));
    assert_drain_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en) |-> $past(local_idle && !refresh_busy));
endmodule

// File: rtl/bus_handover.sv
// Top of the bank bus hand-over arbiter: synchronizer, phase timer, sequencer.
// Assumes: CKE_OFF_MIN >= 1 and SYNC_STAGES >= 1.
module bus_handover #(
    parameter int SYNC_STAGES = 2,
    parameter int CKE_OFF_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req,
    input  logic local_idle,
    input  logic refresh_busy,
    output logic ext_grant,
    output logic bank_cke,
    output logic bank_drive_en,
    output logic local_hold
);
    logic req_s;
    logic phase_start;
    logic window_done;

    ho_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_req),
        .sync_out (req_s)
    );

    ho_phase_timer #(.WINDOW(CKE_OFF_MIN)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_start (phase_start),
        .window_done (window_done)
    );

    ho_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_s        (req_s),
        .local_idle   (local_idle),
        .refresh_busy (refresh_busy),
        .window_done  (window_done),
        .phase_start  (phase_start),
        .grant        (ext_grant),
        .cke          (bank_cke),
        .drive_en     (bank_drive_en),
        .hold         (local_hold)
    );

    assert_hold_covers_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_drive_en) |-> (local_hold && !bank_cke));
    assert_idle_after_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(local_hold) |-> (bank_drive_en && !ext_grant));
endmodule

// File: tb/bus_handover_test.sv
module bus_handover_test;
    localparam int CLK_PERIOD = 10;
    localparam int MINW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req = 1'b0;
    logic local_idle = 1'b1;
    logic refresh_busy = 1'b0;
    logic ext_grant, bank_cke, bank_drive_en, local_hold;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_handover #(.SYNC_STAGES(2), .CKE_OFF_MIN(MINW)) uut (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .local_idle(local_idle),
        .refresh_busy(refresh_busy), .ext_grant(ext_grant), .bank_cke(bank_cke),
        .bank_drive_en(bank_drive_en), .local_hold(local_hold)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            n_checks = n_checks + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 5000", cycles);
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare {grant, cke, drive, hold} against the expected vector.
    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {ext_grant, bank_cke, bank_drive_en, local_hold};
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: {grant,cke,drive,hold} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(3);
        chk("R1 reset", 4'b0110);
        rst_n = 1'b1;
        step(1);
        chk("R1 after reset", 4'b0110);
    endtask

    // Full take-over and hand-back with nothing blocking the drain.
    task automatic t_full_cycle;
        ext_req = 1'b1;
        step(2);
        chk("R2 not yet seen", 4'b0110);
        step(1);
        chk("R2 hold up", 4'b0111);
        step(1);
        chk("R4 cke off first", 4'b0001);
        step(MINW - 1);
        chk("R4 cke off last", 4'b0001);
        step(1);
        chk("R4 grant with cke low", 4'b1001);
        step(1);
        chk("R5 cke back", 4'b1101);
        step(5);
        chk("R6 hold while granted", 4'b1101);
        ext_req = 1'b0;
        step(2);
        chk("R7 still granted", 4'b1101);
        step(1);
        chk("R7 grant and cke drop", 4'b0001);
        step(MINW - 1);
        chk("R7 floated till end", 4'b0001);
        step(1);
        chk("R8 resume drive", 4'b0011);
        step(1);
        chk("R8 idle again", 4'b0110);
    endtask

    // Drain held open by a busy local side, then by a refresh.
    task automatic t_drain_blocked(input bit use_refresh);
        if (use_refresh) refresh_busy = 1'b1; else local_idle = 1'b0;
        ext_req = 1'b1;
        step(3);
        chk(use_refresh ? "R3 refresh blocks start" : "R3 busy blocks start", 4'b0111);
        step(6);
        chk(use_refresh ? "R3 refresh still blocks" : "R3 busy still blocks", 4'b0111);
        refresh_busy = 1'b0;
        local_idle = 1'b1;
        step(1);
        chk("R3 drain complete", 4'b0001);
        step(MINW);
        chk("R4 grant after blocked drain", 4'b1001);
        ext_req = 1'b0;
        step(3 + MINW + 1);
        chk("R8 idle after blocked cycle", 4'b0110);
    endtask

    // Request withdrawn while the drain is still blocked.
    task automatic t_abort;
        local_idle = 1'b0;
        ext_req = 1'b1;
        step(3);
        chk("R9 in drain", 4'b0111);
        ext_req = 1'b0;
        step(3);
        chk("R9 back to idle", 4'b0110);
        local_idle = 1'b1;
        step(MINW + 3);
        chk("R9 no grant later", 4'b0110);
    endtask

    initial begin
        step(1);
        t_reset();
        t_full_cycle();
        t_drain_blocked(1'b0);
        t_drain_blocked(1'b1);
        t_abort();
        t_full_cycle();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule